// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Cached Page Mappings

This block turns a 14-bit virtual address into a 12-bit physical address using 64-byte pages. A small four-way, four-set translation cache holds recent page mappings. A request whose page is cached is answered from the cache. A request whose page is not cached stalls while the block reads the page-table entry for that page over a simple read port. If the fetched entry is present, the block loads it into the cache and completes the translation. If the entry is absent, the block returns a page-fault indication and loads nothing.

Requests use a valid/ready handshake, and only one translation is in flight at a time. Each answer is a one-cycle pulse that carries three things: the physical address, a fault flag, and a flag that says whether the cache answered directly. The requester can therefore tell a cheap hit, a refill and a true fault apart. A flush input discards every cached mapping in one cycle.

Top module: `xlate_unit`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and pt_req_valid_o is 0, and no cached mapping is valid.
- R2: A request is taken only on a clock edge where req_valid_i and req_ready_o are both high. req_ready_o stays low from the cycle after acceptance until the response pulse has been given.
- R3: On a cache hit, rsp_valid_o is high for exactly one cycle, two clock edges after the accepting edge, with rsp_hit_o=1 and rsp_fault_o=0, and no page-table read is issued.
- R4: The page number is vaddr[13:6]. Its bits [1:0] pick the set and bits [7:2] form the tag. The returned address is {physical page (6 bits), vaddr[5:0]}, so the offset is passed through unchanged.
- R5: On a miss, pt_req_valid_o is held high with pt_req_vpn_o steady until pt_rsp_valid_i arrives. A present entry (pt_rsp_present_i=1) is cached, and the response carries rsp_hit_o=0, rsp_fault_o=0 and the fetched page.
- R6: An absent entry gives rsp_fault_o=1, rsp_hit_o=0 and rsp_paddr_o=0, and is not cached, so a repeated request walks the table again.
- R7: A refill goes to the lowest-numbered invalid way of the set. If the set is full, a per-set 2-bit round-robin pointer picks the way. The pointer starts at way 0 after reset, advances by one (mod 4) only on such replacements, and is not cleared by a flush.
- R8: A cycle with flush_i high invalidates every cached mapping, so the next request to any page misses.
- R9: With page 0x0F mapped to physical page 0x0D, address 0x03D4 translates to 0x354. With page 0x00 mapped to 0x28, address 0x0020 translates to 0xA20.
- R10: Sets are independent. Equal tags in different sets are distinct mappings, and refills in one set leave the other sets untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all cached mappings |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_vaddr_i | input | 14 | Virtual address to translate |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_paddr_o | output | 12 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Page not resident |
| rsp_hit_o | output | 1 | Answered from cache without a table read |
| pt_req_valid_o | output | 1 | Page-table read request |
| pt_req_vpn_o | output | 8 | Page number to read |
| pt_rsp_valid_i | input | 1 | Page-table read data valid |
| pt_rsp_ppn_i | input | 6 | Physical page from the table |
| pt_rsp_present_i | input | 1 | Table entry valid |

## Verification
The bench drives the translator with four kinds of traffic and compares each response against a reference model of the cache. Repeated addresses on one page separate hits from refills. Pages whose table entry is absent separate true faults from plain misses. A run of more than four tags into one set shows whether the victim order is first-free and then round-robin. An equal tag placed in a second set, and a flush, show that sets are independent and that the flush removes every mapping. A page-table read counter, checked on every response, catches any hit that quietly reads the table and any fault that leaves a mapping behind.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned VA_W  = 14;
  localparam int unsigned PA_W  = 12;
  localparam int unsigned OFF_W = 6;
  localparam int unsigned SETS  = 4;
  localparam int unsigned WAYS  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WALK,
    ST_RESP
  } xl_state_e;
endpackage

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int unsigned SETS = 4,
  parameter int unsigned WAYS = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] set_i,
  input  logic [WAYS-1:0]  way_valid_i,
  input  logic             alloc_i,
  output logic [WAY_W-1:0] way_o
);
  logic [WAY_W-1:0] rr_q [SETS];
  logic             has_free;

  assign has_free = ~&way_valid_i;

  // lowest free way wins; otherwise round-robin
  always_comb begin
    way_o = rr_q[set_i];
    if (has_free) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!way_valid_i[w]) way_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (alloc_i && !has_free) begin
      rr_q[set_i] <= rr_q[set_i] + 1'b1;
    end
  end

  assert_free_way_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && has_free) |-> !way_valid_i[way_o]);

  assert_rr_advance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !has_free && set_i == 0) |=> (rr_q[0] == $past(rr_q[0]) + 1'b1));
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PPN_W = 6,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [WAYS-1:0]  way_valid_o,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [PPN_W-1:0] wr_ppn_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
  logic [WAYS-1:0]  hit_way;
  logic             any_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_way[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  assign hit_o       = |hit_way;
  assign way_valid_o = valid_q[set_i];

  always_comb begin
    ppn_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_way[w]) ppn_o = ppn_o | ppn_q[set_i][w];
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  // flush wins over a same-cycle refill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en_i) begin
      valid_q[set_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[set_i][wr_way_i] <= tag_i;
      ppn_q[set_i][wr_way_i] <= wr_ppn_i;
    end
  end

  assert_unique_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_way));

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !any_valid);
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int unsigned VA_W_P  = VA_W,
  parameter int unsigned PA_W_P  = PA_W,
  parameter int unsigned OFF_W_P = OFF_W,
  parameter int unsigned SETS_P  = SETS,
  parameter int unsigned WAYS_P  = WAYS,
  localparam int unsigned VPN_W = VA_W_P - OFF_W_P,
  localparam int unsigned PPN_W = PA_W_P - OFF_W_P,
  localparam int unsigned IDX_W = $clog2(SETS_P),
  localparam int unsigned TAG_W = VPN_W - IDX_W,
  localparam int unsigned WAY_W = $clog2(WAYS_P)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W_P-1:0] req_vaddr_i,
  output logic              rsp_valid_o,
  output logic [PA_W_P-1:0] rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic              rsp_hit_o,
  output logic              pt_req_valid_o,
  output logic [VPN_W-1:0]  pt_req_vpn_o,
  input  logic              pt_rsp_valid_i,
  input  logic [PPN_W-1:0]  pt_rsp_ppn_i,
  input  logic              pt_rsp_present_i
);
  xl_state_e         state_q;
  logic [VA_W_P-1:0] vaddr_q;
  logic [PA_W_P-1:0] paddr_q;
  logic              fault_q, hit_q;

  logic [VPN_W-1:0]   vpn;
  logic [IDX_W-1:0]   set_idx;
  logic [TAG_W-1:0]   tag;
  logic [OFF_W_P-1:0] off;
  logic               lk_hit;
  logic [PPN_W-1:0]   lk_ppn;
  logic [WAYS_P-1:0]  way_valid;
  logic [WAY_W-1:0]   victim;
  logic               refill;

  assign vpn     = vaddr_q[VA_W_P-1:OFF_W_P];
  assign set_idx = vpn[IDX_W-1:0];
  assign tag     = vpn[VPN_W-1:IDX_W];
  assign off     = vaddr_q[OFF_W_P-1:0];
  assign refill  = (state_q == ST_WALK) && pt_rsp_valid_i && pt_rsp_present_i;

  xlate_tlb #(
    .SETS (SETS_P),
    .WAYS (WAYS_P),
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .set_i      (set_idx),
    .tag_i      (tag),
    .hit_o      (lk_hit),
    .ppn_o      (lk_ppn),
    .way_valid_o(way_valid),
    .wr_en_i    (refill),
    .wr_way_i   (victim),
    .wr_ppn_i   (pt_rsp_ppn_i)
  );

  xlate_victim #(
    .SETS(SETS_P),
    .WAYS(WAYS_P)
  ) u_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_idx),
    .way_valid_i(way_valid),
    .alloc_i    (refill),
    .way_o      (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (lk_hit) begin
          paddr_q <= {lk_ppn, off};
          fault_q <= 1'b0;
          hit_q   <= 1'b1;
          state_q <= ST_RESP;
        end else begin
          state_q <= ST_WALK;
        end
        ST_WALK: if (pt_rsp_valid_i) begin
          paddr_q <= pt_rsp_present_i ? {pt_rsp_ppn_i, off} : '0;
          fault_q <= !pt_rsp_present_i;
          hit_q   <= 1'b0;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign rsp_valid_o    = (state_q == ST_RESP);
  assign rsp_paddr_o    = paddr_q;
  assign rsp_fault_o    = fault_q;
  assign rsp_hit_o      = hit_q;
  assign pt_req_valid_o = (state_q == ST_WALK);
  assign pt_req_vpn_o   = vpn;

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_hit_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> $past(state_q == ST_LOOK));

  assert_offset_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[OFF_W_P-1:0] == vaddr_q[OFF_W_P-1:0]));

  assert_walk_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_req_valid_o && !pt_rsp_valid_i) |=> (pt_req_valid_o && $stable(pt_req_vpn_o)));

  assert_fault_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (!rsp_hit_o && rsp_paddr_o == '0));
endmodule

// File: tb/xlate_unit_test.sv
module xlate_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic        pt_rsp_valid = 1'b0;
  logic [5:0]  pt_rsp_ppn = '0;
  logic        pt_rsp_present = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_hit, pt_req_valid;
  logic [11:0] rsp_paddr;
  logic [7:0]  pt_req_vpn;

  always #5 clk = ~clk;

  xlate_unit uut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .flush_i         (flush),
    .req_valid_i     (req_valid),
    .req_ready_o     (req_ready),
    .req_vaddr_i     (req_vaddr),
    .rsp_valid_o     (rsp_valid),
    .rsp_paddr_o     (rsp_paddr),
    .rsp_fault_o     (rsp_fault),
    .rsp_hit_o       (rsp_hit),
    .pt_req_valid_o  (pt_req_valid),
    .pt_req_vpn_o    (pt_req_vpn),
    .pt_rsp_valid_i  (pt_rsp_valid),
    .pt_rsp_ppn_i    (pt_rsp_ppn),
    .pt_rsp_present_i(pt_rsp_present)
  );

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  int walk_cnt = 0;
  int exp_walks = 0;
  logic [11:0] last_pa = '0;

  // page table contents
  logic [5:0] pt_ppn [256];
  bit         pt_ok  [256];

  // reference cache model
  bit       m_v   [4][4];
  bit [5:0] m_tag [4][4];
  bit [5:0] m_ppn [4][4];
  bit [1:0] m_rr  [4];

  // scoreboard
  logic [11:0] q_pa[$];
  bit          q_fault[$];
  bit          q_hit[$];
  int          q_walks[$];
  int          q_acc[$];
  string       q_rq[$];

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // page-table responder: two-cycle read latency
  int pt_wait = 0;
  always @(negedge clk) begin
    if (pt_rsp_valid) begin
      pt_rsp_valid = 1'b0;
      pt_wait = 0;
    end else if (pt_req_valid) begin
      pt_wait++;
      if (pt_wait == 2) begin
        pt_rsp_valid   = 1'b1;
        pt_rsp_ppn     = pt_ppn[pt_req_vpn];
        pt_rsp_present = pt_ok[pt_req_vpn];
        walk_cnt++;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_pa.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        logic [11:0] e_pa;
        bit e_f, e_h;
        int e_w, e_a;
        string rq;
        e_pa = q_pa.pop_front();
        e_f  = q_fault.pop_front();
        e_h  = q_hit.pop_front();
        e_w  = q_walks.pop_front();
        e_a  = q_acc.pop_front();
        rq   = q_rq.pop_front();
        check(rsp_paddr == e_pa, rq, "paddr", int'(rsp_paddr), int'(e_pa));
        check(rsp_fault == e_f, rq, "fault", int'(rsp_fault), int'(e_f));
        check(rsp_hit == e_h, rq, "hit", int'(rsp_hit), int'(e_h));
        check(walk_cnt == e_w, rq, "table reads", walk_cnt, e_w);
        if (e_h) check((cyc - e_a) == 2, "R3", "hit latency", cyc - e_a, 2);
        last_pa = rsp_paddr;
      end
    end
  end

  task automatic translate(input logic [13:0] va, input string rq);
    logic [7:0] vpn;
    logic [1:0] s;
    logic [5:0] tg, ppn;
    logic [11:0] pa;
    bit hit, fault, found;
    logic [1:0] vic;
    vpn = va[13:6];
    s = vpn[1:0];
    tg = vpn[7:2];
    hit = 1'b0;
    fault = 1'b0;
    ppn = '0;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_tag[s][w] == tg) begin
        hit = 1'b1;
        ppn = m_ppn[s][w];
      end
    if (hit) begin
      pa = {ppn, va[5:0]};
    end else begin
      exp_walks++;
      if (pt_ok[vpn]) begin
        found = 1'b0;
        vic = '0;
        for (int w = 0; w < 4; w++)
          if (!found && !m_v[s][w]) begin
            vic = 2'(w);
            found = 1'b1;
          end
        if (!found) begin
          vic = m_rr[s];
          m_rr[s] = m_rr[s] + 1'b1;
        end
        m_v[s][vic] = 1'b1;
        m_tag[s][vic] = tg;
        m_ppn[s][vic] = pt_ppn[vpn];
        pa = {pt_ppn[vpn], va[5:0]};
      end else begin
        fault = 1'b1;
        pa = '0;
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    q_pa.push_back(pa);
    q_fault.push_back(fault);
    q_hit.push_back(hit);
    q_walks.push_back(exp_walks);
    q_acc.push_back(cyc);
    q_rq.push_back(rq);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2", "ready after accept", int'(req_ready), 0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    flush = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic drain();
    while (q_pa.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int v = 0; v < 256; v++) begin
      pt_ppn[v] = 6'((v * 5 + 3) % 64);
      pt_ok[v]  = (v % 7) != 6;
    end
    pt_ppn[8'h00] = 6'h28; pt_ok[8'h00] = 1'b1;
    pt_ppn[8'h0F] = 6'h0D; pt_ok[8'h0F] = 1'b1;
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = '0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
    end

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    check(pt_req_valid == 1'b0, "R1", "pt_req after reset", int'(pt_req_valid), 0);

    // R9 / R5: first access walks, second hits
    translate(14'h03D4, "R5");
    drain();
    check(last_pa == 12'h354, "R9", "0x03D4 refill", int'(last_pa), 12'h354);
    translate(14'h03D4, "R3");
    drain();
    check(last_pa == 12'h354, "R9", "0x03D4 hit", int'(last_pa), 12'h354);
    translate(14'h0020, "R5");
    drain();
    check(last_pa == 12'hA20, "R9", "0x0020 refill", int'(last_pa), 12'hA20);
    translate(14'h003F, "R4");

    // R6: absent page faults and is not cached
    translate({8'h06, 6'h11}, "R6");
    translate({8'h06, 6'h22}, "R6");

    // R7: overfill set 1, then revisit
    for (int t = 0; t < 10; t++) translate({6'(t), 2'b01, 6'(t * 3)}, "R7");
    for (int t = 0; t < 10; t++) translate({6'(t), 2'b01, 6'(t + 7)}, "R7");
    for (int t = 9; t >= 0; t--) translate({6'(t), 2'b01, 6'h2A}, "R7");

    // R10: same tag in another set
    translate({6'h05, 2'b10, 6'h01}, "R10");
    translate({6'h05, 2'b01, 6'h02}, "R10");
    translate({6'h05, 2'b10, 6'h03}, "R10");
    translate(14'h03D4, "R10");

    // R8: flush drops everything
    drain();
    do_flush();
    translate(14'h03D4, "R8");
    translate(14'h0020, "R8");
    translate({6'h05, 2'b10, 6'h04}, "R8");

    // mixed traffic
    for (int i = 0; i < 40; i++)
      translate(14'((i * 389 + 77) % 16384), "R4");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule